// File: doc/BRIEF.md
# Parity Bus Transceiver

This block moves a byte-wide word between two bus sides, A and B, and protects the word with one parity bit. A direction input selects the flow. In transmit mode, side A drives side B, and the block computes the parity bit and drives it onto a shared parity line. In receive mode, side B drives side A. The parity line then becomes an input, and the block compares it with the received word. An active-low error flag reports any mismatch. A select input chooses between even and odd parity.

Each bidirectional pin is split into three parts: an input value, an output value and an active-high drive enable. The pad ring therefore builds the real three-state buffers. An active-low global enable releases every driver at once. The block holds no state: every output is a combinational function of the inputs.

Top module: `parity_bus_xcvr`

## Requirements
- R1: With the block enabled (oe_ni = 0) and dir_tx_i = 1, b_o equals a_i bit for bit and b_oe_o = 1. With dir_tx_i = 0, a_o equals b_i bit for bit and a_oe_o = 1. Data is never inverted.
- R2: With oe_ni = 1, the drive enables a_oe_o, b_oe_o, par_oe_o and err_oe_o are all 0, whatever the other inputs are.
- R3: Whenever a drive enable is 0, the value output it qualifies rests at its idle level: a_o = 0, b_o = 0, par_o = 0, err_no = 1.
- R4: In transmit mode with odd_sel_i = 0 (even parity), par_o = 1 exactly when a_i holds an odd number of ones. With odd_sel_i = 1 (odd parity), par_o is the inverse. par_oe_o = 1 in transmit mode while the block is enabled.
- R5: In receive mode with odd_sel_i = 0, err_no = 1 (no error) when the number of ones in b_i plus par_i is even, and err_no = 0 otherwise.
- R6: In receive mode with odd_sel_i = 1, err_no = 1 when the number of ones in b_i plus par_i is odd, and err_no = 0 otherwise.
- R7: err_oe_o = 1 only in receive mode while the block is enabled. par_oe_o = 1 only in transmit mode while the block is enabled. In transmit mode par_i has no effect on any output.
- R8: While the block is enabled, exactly one of a_oe_o and b_oe_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oe_ni | input | 1 | Global enable, active low; when high, every driver is released |
| dir_tx_i | input | 1 | 1 = transmit (A to B), 0 = receive (B to A) |
| odd_sel_i | input | 1 | 0 = even parity, 1 = odd parity |
| a_i | input | DATA_W | Value sensed on side A |
| a_o | output | DATA_W | Value to drive on side A |
| a_oe_o | output | 1 | Drive enable for side A |
| b_i | input | DATA_W | Value sensed on side B |
| b_o | output | DATA_W | Value to drive on side B |
| b_oe_o | output | 1 | Drive enable for side B |
| par_i | input | 1 | Value sensed on the parity line |
| par_o | output | 1 | Parity bit to drive on the parity line |
| par_oe_o | output | 1 | Drive enable for the parity line |
| err_no | output | 1 | Parity error flag, active low |
| err_oe_o | output | 1 | Drive enable for the error flag |

## Verification
The assertions check the following at every input change:
- the driver enables are exclusive and follow the direction and enable inputs;
- released outputs rest at their idle levels;
- the transmitted word, with par_o appended, always carries the selected parity;
- the error flag always agrees with the parity of the passed-through word and par_i.

Every one of these properties compares two parity trees with the data muxes, so a fault that corrupts a tree and a mux in the same way would escape them. The bench covers that gap. It compares every byte value in both directions, under both parity selects and both parity-line levels, against a bit-count model. It also shows with directed vectors that par_i is ignored while transmitting.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  typedef struct packed {
    logic a;
    logic b;
    logic par;
    logic err;
  } drive_en_t;

endpackage

// File: rtl/pbt_parity_tree.sv
module pbt_parity_tree #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  output logic              odd_o
);

  localparam int unsigned LEVELS = (DATA_W > 1) ? $clog2(DATA_W) : 0;
  localparam int unsigned PAD_W  = 1 << LEVELS;
  localparam int unsigned NODES  = 2 * PAD_W - 1;

  // heap layout: node k has children 2k+1 and 2k+2, leaves at PAD_W-1..
  logic [NODES-1:0] node;

  for (genvar j = 0; j < PAD_W; j++) begin : g_leaf
    if (j < DATA_W) begin : g_data
      assign node[PAD_W-1+j] = data_i[j];
    end else begin : g_pad
      assign node[PAD_W-1+j] = 1'b0;
    end
  end

  for (genvar k = 0; k < PAD_W - 1; k++) begin : g_inner
    assign node[k] = node[2*k+1] ^ node[2*k+2];
  end

  assign odd_o = node[0];

endmodule

// File: rtl/pbt_dir_ctrl.sv
module pbt_dir_ctrl
  import pbt_pkg::*;
(
  input  logic      oe_ni,
  input  logic      dir_tx_i,
  output drive_en_t en_o
);

  dir_e dir;
  logic active;

  assign dir    = dir_e'(dir_tx_i);
  assign active = ~oe_ni;

  always_comb begin
    en_o = '0;
    if (active) begin
      unique case (dir)
        DIR_TX: begin
          en_o.b   = 1'b1;
          en_o.par = 1'b1;
        end
        DIR_RX: begin
          en_o.a   = 1'b1;
          en_o.err = 1'b1;
        end
        default: en_o = '0;
      endcase
    end
  end

  always_comb begin
    if (!oe_ni) begin
      a_r8_one_side: assert ($countones({en_o.a, en_o.b}) == 1)
        else $error("R8: data enables not exclusive");
    end
  end

endmodule

// File: rtl/pbt_port_mux.sv
module pbt_port_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] data_o
);

  // released side rests at zero so downstream compare logic never sees X
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign data_o[i] = data_i[i] & en_i;
  end

endmodule

// File: rtl/parity_bus_xcvr.sv
module parity_bus_xcvr
  import pbt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              oe_ni,
  input  logic              dir_tx_i,
  input  logic              odd_sel_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_oe_o,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] b_o,
  output logic              b_oe_o,
  input  logic              par_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              err_no,
  output logic              err_oe_o
);

  drive_en_t en;
  logic      a_odd;
  logic      b_odd;
  logic      mismatch;

  pbt_dir_ctrl i_dir_ctrl (
    .oe_ni    (oe_ni),
    .dir_tx_i (dir_tx_i),
    .en_o     (en)
  );

  pbt_port_mux #(.DATA_W(DATA_W)) i_mux_to_b (
    .data_i (a_i),
    .en_i   (en.b),
    .data_o (b_o)
  );

  pbt_port_mux #(.DATA_W(DATA_W)) i_mux_to_a (
    .data_i (b_i),
    .en_i   (en.a),
    .data_o (a_o)
  );

  pbt_parity_tree #(.DATA_W(DATA_W)) i_tree_a (
    .data_i (a_i),
    .odd_o  (a_odd)
  );

  pbt_parity_tree #(.DATA_W(DATA_W)) i_tree_b (
    .data_i (b_i),
    .odd_o  (b_odd)
  );

  // received word plus parity bit must have parity equal to odd_sel_i
  assign mismatch = b_odd ^ par_i ^ odd_sel_i;

  assign par_o    = en.par & (a_odd ^ odd_sel_i);
  assign err_no   = ~(en.err & mismatch);
  assign a_oe_o   = en.a;
  assign b_oe_o   = en.b;
  assign par_oe_o = en.par;
  assign err_oe_o = en.err;

  always_comb begin
    if (oe_ni) begin
      a_r2_release: assert ({a_oe_o, b_oe_o, par_oe_o, err_oe_o} == 4'b0000)
        else $error("R2: driver active while disabled");
    end
    a_r3_idle_a: assert (a_oe_o || (a_o == '0))
      else $error("R3: side A not idle");
    a_r3_idle_b: assert (b_oe_o || (b_o == '0))
      else $error("R3: side B not idle");
    a_r3_idle_flags: assert ((par_oe_o || !par_o) && (err_oe_o || err_no))
      else $error("R3: flags not idle");
    if (b_oe_o) begin
      a_r1_pass_to_b: assert (b_o == a_i) else $error("R1: A->B corrupted");
    end
    if (a_oe_o) begin
      a_r1_pass_to_a: assert (a_o == b_i) else $error("R1: B->A corrupted");
    end
    if (par_oe_o && b_oe_o) begin
      a_r4_sent_word: assert ((^{b_o, par_o}) == odd_sel_i)
        else $error("R4: sent word parity wrong");
    end
    if (err_oe_o && a_oe_o) begin
      a_r5_r6_check: assert (err_no == ((^{a_o, par_i}) == odd_sel_i))
        else $error("R5/R6: error flag wrong");
    end
    a_r7_flag_excl: assert (!(par_oe_o && err_oe_o) &&
                            (!par_oe_o || b_oe_o) && (!err_oe_o || a_oe_o))
      else $error("R7: flag enables inconsistent");
  end

endmodule

// File: tb/test_parity_bus_xcvr.sv
module test_parity_bus_xcvr;

  localparam int unsigned W = 8;

  typedef struct packed {
    logic         oe_n;
    logic         dir;
    logic         odd;
    logic         pi;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         x_aoe;
    logic         x_boe;
    logic         x_poe;
    logic         x_eoe;
    logic [W-1:0] x_ao;
    logic [W-1:0] x_bo;
    logic         x_po;
    logic         x_en;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,8'h00,8'h5A, 1'b0,1'b1,1'b1,1'b0, 8'h00,8'h00,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,8'h07,8'hFF, 1'b0,1'b1,1'b1,1'b0, 8'h00,8'h07,1'b1,1'b1},
    '{1'b0,1'b1,1'b1,1'b0,8'h07,8'hFF, 1'b0,1'b1,1'b1,1'b0, 8'h00,8'h07,1'b0,1'b1},
    '{1'b0,1'b1,1'b1,1'b1,8'hF0,8'h00, 1'b0,1'b1,1'b1,1'b0, 8'h00,8'hF0,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,8'hFF,8'h03, 1'b1,1'b0,1'b0,1'b1, 8'h03,8'h00,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,8'hFF,8'h01, 1'b1,1'b0,1'b0,1'b1, 8'h01,8'h00,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,1'b0,8'h00,8'h01, 1'b1,1'b0,1'b0,1'b1, 8'h01,8'h00,1'b0,1'b1},
    '{1'b0,1'b0,1'b1,1'b0,8'h00,8'h81, 1'b1,1'b0,1'b0,1'b1, 8'h81,8'h00,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b1,8'hFF,8'hAA, 1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,1'b0,1'b1},
    '{1'b1,1'b0,1'b1,1'b1,8'hFF,8'hAA, 1'b0,1'b0,1'b0,1'b0, 8'h00,8'h00,1'b0,1'b1}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         oe_ni, dir_tx_i, odd_sel_i, par_i;
  logic [W-1:0] a_i, b_i, a_o, b_o;
  logic         a_oe_o, b_oe_o, par_o, par_oe_o, err_no, err_oe_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  parity_bus_xcvr #(.DATA_W(W)) i_parity_bus_xcvr (
    .oe_ni, .dir_tx_i, .odd_sel_i, .a_i, .a_o, .a_oe_o, .b_i, .b_o, .b_oe_o,
    .par_i, .par_o, .par_oe_o, .err_no, .err_oe_o
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic oe_n, input logic dir, input logic odd,
                       input logic pi, input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    #1;
    oe_ni = oe_n; dir_tx_i = dir; odd_sel_i = odd; par_i = pi; a_i = a; b_i = b;
    @(negedge clk);
  endtask

  initial begin
    oe_ni = 1'b1; dir_tx_i = 1'b0; odd_sel_i = 1'b0; par_i = 1'b0;
    a_i = '0; b_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset-time state: block released
    chk("R2 reset enables", {4'b0, a_oe_o, b_oe_o, par_oe_o, err_oe_o}, 8'h00);
    chk("R3 reset err_no", {7'b0, err_no}, 8'h01);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v].oe_n, VEC[v].dir, VEC[v].odd, VEC[v].pi, VEC[v].a, VEC[v].b);
      chk("R2 R7 R8 table enables", {4'b0, a_oe_o, b_oe_o, par_oe_o, err_oe_o},
          {4'b0, VEC[v].x_aoe, VEC[v].x_boe, VEC[v].x_poe, VEC[v].x_eoe});
      chk("R1 R3 table a_o", a_o, VEC[v].x_ao);
      chk("R1 R3 table b_o", b_o, VEC[v].x_bo);
      chk("R4 table par_o", {7'b0, par_o}, {7'b0, VEC[v].x_po});
      chk("R5 R6 table err_no", {7'b0, err_no}, {7'b0, VEC[v].x_en});
    end

    // exhaustive sweep against a bit-count model
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 2; p++) begin
          for (int val = 0; val < 256; val++) begin
            logic [W-1:0] x;
            logic pc;
            x  = W'(val);
            pc = logic'($countones(x) % 2);
            if (d == 1) begin
              drive(1'b0, 1'b1, logic'(s), logic'(p), x, ~x);
              chk("R1 sweep b_o", b_o, x);
              chk("R4 sweep par_o", {7'b0, par_o}, {7'b0, pc ^ logic'(s)});
              chk("R7 R8 sweep tx enables", {4'b0, a_oe_o, b_oe_o, par_oe_o, err_oe_o}, 8'h06);
              chk("R3 R7 sweep tx idle", {6'b0, a_o == '0, err_no}, 8'h03);
            end else begin
              drive(1'b0, 1'b0, logic'(s), logic'(p), ~x, x);
              chk("R1 sweep a_o", a_o, x);
              if (s == 0)
                chk("R5 sweep err_no", {7'b0, err_no}, {7'b0, (pc ^ logic'(p)) == 1'b0});
              else
                chk("R6 sweep err_no", {7'b0, err_no}, {7'b0, (pc ^ logic'(p)) == 1'b1});
              chk("R7 R8 sweep rx enables", {4'b0, a_oe_o, b_oe_o, par_oe_o, err_oe_o}, 8'h09);
              chk("R3 sweep rx idle", {6'b0, b_o == '0, par_o}, 8'h02);
            end
          end
        end
      end
    end

    // R7: flipping par_i in transmit mode leaves every output unchanged
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h3C, 8'h00);
    chk("R7 tx par_i=0 outputs", {b_o}, 8'h3C);
    chk("R7 tx par_i=0 flags", {6'b0, par_o, err_no}, 8'h03);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, 8'h00);
    chk("R7 tx par_i=1 outputs", {b_o}, 8'h3C);
    chk("R7 tx par_i=1 flags", {6'b0, par_o, err_no}, 8'h03);
    // R2 with a wrong-parity receive pattern that would otherwise flag an error
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    chk("R2 R3 disabled err_no", {7'b0, err_no}, 8'h01);
    chk("R2 disabled enables", {4'b0, a_oe_o, b_oe_o, par_oe_o, err_oe_o}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule